// File: doc/BRIEF.md
# Configuration item selector and data port

This block lets a host read a fixed table of byte-string configuration items. The host first writes a 16-bit key to pick an item, then reads the data register again and again. Each read returns the next bytes of the item and moves a per-item byte offset forward. Item contents sit in a parameterised ROM image, and a lookup table gives each item its base address and length. The lookup is indexed by a bank bit together with a 14-bit item index. Keys at or above a configurable limit (first file key plus file slot count, 0x20 + 0x20 by default) select nothing.

Two front ends share one selector state. The split mapping has a control register that takes key writes and a data register that serves wide reads of 1 to 8 bytes. The combined port mapping puts both on one location and tells them apart by access size. Every access gets a response in the following cycle. A rejected access returns zero and pulses an error flag for one cycle.

Top module: `cfgsel_port`

## Requirements
- R1: After reset, key 0 is selected at offset 0. Key 0 holds a 4-byte signature whose bytes are served in the order SIG_WORD[31:24], [23:16], [15:8], [7:0] (default 0x43, 0x46, 0x47, 0x53). While reset is asserted, rsp_valid, rsp_err and rsp_rdata are 0.
- R2: Every accepted key write selects bank acc_wdata[15] and index acc_wdata[13:0], and sets the byte offset to zero, even when the key is unchanged.
- R3: Bit 14 of a key is ignored. If the index is not below FIRST_FILE + FILE_SLOTS (0x40 by default), data reads return zero and move no offset, whatever the table holds for that key.
- R4: Key bit 15 selects a second bank, so keys 0x0020 and 0x8020 reach different items.
- R5: A data read of N bytes (1 to 8) returns the item bytes from the current offset. The first byte goes in the most significant of the N low bytes of rsp_rdata. The offset advances by the number of bytes delivered. If the item ends early, the remaining low bytes are zero. The response appears in the cycle after the access, with rsp_valid high.
- R6: A read with the offset at or past the item length, or on a key with no item, returns zero and does not advance the offset.
- R7: Writes to the data register (acc_space 1, size 1 to 8) and 1-byte writes on the combined port are accepted without error and change no state.
- R8: The split control register (acc_space 0) accepts only 2-byte writes. Reads of it and writes of any other size are rejected.
- R9: On the combined port (acc_space 2), a 1-byte read is a 1-byte data read, a 1-byte write is ignored, and a 2-byte write selects a key. A 2-byte read and every other size are rejected.
- R10: A rejected access returns rsp_rdata zero and raises rsp_err for exactly one cycle, and it changes neither the key nor the offset. Rejected accesses are: the R8 and R9 cases, a data register access of size 0 or above 8, and acc_space 3.
- R11: Key 0x0001 is the 4-byte version item, served little-endian: byte 0 is 0x01 plus 0x02 when DMA_EN is set, and the other bytes are 0.
- R12: The item table holds:
  - bank 0: index 0x02 (empty), 0x20 (11 bytes) and 0x3F (2 bytes);
  - bank 1: index 0x20 (5 bytes) and 0x40 (3 bytes, unreachable under the default limit).

  Byte i of each of these items is {bank, index[2:0], i[3:0]}. Bank 1 index 0 has no item.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_valid | input | 1 | Access request, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_space | input | 2 | 0 split control, 1 split data, 2 combined port, 3 unmapped |
| acc_size | input | 4 | Access size in bytes |
| acc_wdata | input | 16 | Write data; key for selector writes |
| rsp_valid | output | 1 | Response for the access of the previous cycle |
| rsp_rdata | output | 64 | Read data, zero for writes and rejects |
| rsp_err | output | 1 | One-cycle pulse for a rejected access |

## Verification
Reads of 1, 2, 3, 4 and 8 bytes are tried against items of 2, 4, 5 and 11 bytes. Starting them at different offsets tells correct byte order and offset advance apart from partial zero padding and from the read that lands exactly at the end. Neighbouring keys 0x003F and 0x0040, a bank-1 twin of a bank-0 item, and a key with bit 14 set separate the range check, the bank decode and the mask. After each ignored write and each rejected access the bench reads data again to confirm that the offset stayed put. It also reselects the same key to confirm that the offset returns to zero.

// File: rtl/cfgsel_pkg.sv
package cfgsel_pkg;

  localparam int KEY_W     = 16;
  localparam int IDX_W     = 14;
  localparam int BANK_POS  = 15;
  localparam int LEN_W     = 8;
  localparam int SZ_W      = 4;
  localparam int NUM_ITEMS = 7;

  typedef enum logic [1:0] {
    SP_CTL  = 2'd0,
    SP_DATA = 2'd1,
    SP_COMB = 2'd2,
    SP_NONE = 2'd3
  } space_e;

  typedef enum logic [1:0] {
    K_SIG = 2'd0,
    K_VER = 2'd1,
    K_PAT = 2'd2
  } kind_e;

  typedef struct packed {
    kind_e            kind;
    logic             bank;
    logic [IDX_W-1:0] idx;
    logic [LEN_W-1:0] len;
  } item_t;

  // Item table: kind, bank, index, length in bytes.
  function automatic item_t item_def(input int i);
    item_t it;
    it = '{kind: K_PAT, bank: 1'b0, idx: '0, len: '0};
    case (i)
      0: it = '{kind: K_SIG, bank: 1'b0, idx: 14'h0000, len: 8'd4};
      1: it = '{kind: K_VER, bank: 1'b0, idx: 14'h0001, len: 8'd4};
      2: it = '{kind: K_PAT, bank: 1'b0, idx: 14'h0002, len: 8'd0};
      3: it = '{kind: K_PAT, bank: 1'b0, idx: 14'h0020, len: 8'd11};
      4: it = '{kind: K_PAT, bank: 1'b1, idx: 14'h0020, len: 8'd5};
      5: it = '{kind: K_PAT, bank: 1'b0, idx: 14'h003F, len: 8'd2};
      6: it = '{kind: K_PAT, bank: 1'b1, idx: 14'h0040, len: 8'd3};
      default: it = '{kind: K_PAT, bank: 1'b0, idx: '0, len: '0};
    endcase
    return it;
  endfunction

  // Items are packed back to back in the image.
  function automatic int item_base(input int i);
    int s;
    s = 0;
    for (int j = 0; j < i; j++) s += int'(item_def(j).len);
    return s;
  endfunction

  localparam int IMG_BYTES = item_base(NUM_ITEMS);

  // Byte at flat image address a; zero outside every item.
  function automatic logic [7:0] img_byte(input int a, input logic [31:0] sig,
                                          input logic dma_en);
    logic [7:0] b;
    b = 8'h00;
    for (int i = 0; i < NUM_ITEMS; i++) begin
      item_t it;
      int    lo;
      int    k;
      it = item_def(i);
      lo = item_base(i);
      k  = a - lo;
      if (a >= lo && a < lo + int'(it.len)) begin
        case (it.kind)
          K_SIG:   b = sig[31-8*(k%4) -: 8];
          K_VER:   b = (k == 0) ? {6'b0, dma_en, 1'b1} : 8'h00;
          default: b = {it.bank, it.idx[2:0], 4'(k)};
        endcase
      end
    end
    return b;
  endfunction

endpackage

// File: rtl/cfgsel_decode.sv
module cfgsel_decode
  import cfgsel_pkg::*;
#(
  parameter int MAX_RD = 8
) (
  input  logic            acc_valid,
  input  logic            acc_write,
  input  logic [1:0]      acc_space,
  input  logic [SZ_W-1:0] acc_size,
  output logic            sel_we,
  output logic            rd_en,
  output logic            ign_wr,
  output logic            reject,
  output logic [SZ_W-1:0] rd_size
);

  logic wide_ok;
  assign wide_ok = (acc_size >= SZ_W'(1)) && (acc_size <= SZ_W'(MAX_RD));

  always_comb begin
    sel_we  = 1'b0;
    rd_en   = 1'b0;
    ign_wr  = 1'b0;
    reject  = 1'b0;
    rd_size = '0;
    if (acc_valid) begin
      case (space_e'(acc_space))
        SP_CTL: begin
          if (acc_write && acc_size == SZ_W'(2)) sel_we = 1'b1;
          else                                    reject = 1'b1;
        end
        SP_DATA: begin
          if (!wide_ok)       reject = 1'b1;
          else if (acc_write) ign_wr = 1'b1;
          else begin
            rd_en   = 1'b1;
            rd_size = acc_size;
          end
        end
        SP_COMB: begin
          if (acc_size == SZ_W'(1)) begin
            if (acc_write) ign_wr = 1'b1;
            else begin
              rd_en   = 1'b1;
              rd_size = SZ_W'(1);
            end
          end else if (acc_size == SZ_W'(2) && acc_write) begin
            sel_we = 1'b1;
          end else begin
            reject = 1'b1;
          end
        end
        default: reject = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/cfgsel_state.sv
module cfgsel_state
  import cfgsel_pkg::*;
#(
  parameter int FIRST_FILE = 32,
  parameter int FILE_SLOTS = 32,
  parameter int AW         = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_we,
  input  logic             sel_bank,
  input  logic [IDX_W-1:0] sel_idx,
  input  logic             rd_en,
  input  logic [LEN_W-1:0] adv,
  output logic             key_ok,
  output logic [AW-1:0]    cur_base,
  output logic [LEN_W-1:0] cur_len,
  output logic [LEN_W-1:0] off
);

  localparam int LIM_W = IDX_W + 1;
  localparam logic [LIM_W-1:0] LIMIT = LIM_W'(FIRST_FILE + FILE_SLOTS);

  logic             bank_q, bank_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic [LEN_W-1:0] off_q, off_n;
  logic             upd;

  // Next-state logic
  always_comb begin
    bank_n = bank_q;
    idx_n  = idx_q;
    off_n  = off_q;
    upd    = 1'b0;
    if (sel_we) begin
      upd    = 1'b1;
      bank_n = sel_bank;
      idx_n  = sel_idx;
      off_n  = '0;
    end else if (rd_en && adv != '0) begin
      upd   = 1'b1;
      off_n = off_q + adv;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= 1'b0;
      idx_q  <= '0;
      off_q  <= '0;
    end else if (upd) begin
      bank_q <= bank_n;
      idx_q  <= idx_n;
      off_q  <= off_n;
    end
  end

  assign off    = off_q;
  assign key_ok = {1'b0, idx_q} < LIMIT;

  // Lookup from {bank, index} to base and length
  logic [NUM_ITEMS-1:0] hit;
  logic [AW-1:0]        base_tab [NUM_ITEMS];
  logic [LEN_W-1:0]     len_tab  [NUM_ITEMS];

  for (genvar g = 0; g < NUM_ITEMS; g++) begin : g_item
    localparam item_t IT = item_def(g);
    assign hit[g]      = (IT.bank == bank_q) && (IT.idx == idx_q);
    assign base_tab[g] = AW'(item_base(g));
    assign len_tab[g]  = IT.len;
  end

  always_comb begin
    cur_base = '0;
    cur_len  = '0;
    for (int i = 0; i < NUM_ITEMS; i++) begin
      if (hit[i] && key_ok) begin
        cur_base = base_tab[i];
        cur_len  = len_tab[i];
      end
    end
  end

  AST_SEL_CLEARS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    sel_we |=> off_q == '0);  // R2
  AST_OFF_WITHIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    off_q <= cur_len);  // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_we && !rd_en) |=> $stable(off_q) && $stable(idx_q) && $stable(bank_q));  // R10
  AST_BAD_KEY_NO_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !sel_we && !key_ok) |=> $stable(off_q));  // R3

endmodule

// File: rtl/cfgsel_lanes.sv
module cfgsel_lanes
  import cfgsel_pkg::*;
#(
  parameter int MAX_RD = 8,
  parameter int AW     = 5
) (
  input  logic                          key_ok,
  input  logic [AW-1:0]                 base,
  input  logic [LEN_W-1:0]              len,
  input  logic [LEN_W-1:0]              off,
  input  logic [SZ_W-1:0]               rd_size,
  input  logic [MAX_RD-1:0][7:0]        lane_byte,
  output logic [MAX_RD-1:0][AW-1:0]     lane_addr,
  output logic [8*MAX_RD-1:0]           value,
  output logic [LEN_W-1:0]              adv
);

  localparam int VW = 8 * MAX_RD;

  logic [LEN_W-1:0] remain;
  logic [LEN_W-1:0] req;
  logic             have;
  logic [LEN_W-1:0] n;

  assign have   = key_ok && (off < len);
  assign remain = len - off;
  assign req    = LEN_W'(rd_size);
  assign n      = have ? ((req < remain) ? req : remain) : '0;
  assign adv    = n;

  for (genvar p = 0; p < MAX_RD; p++) begin : g_lane
    assign lane_addr[p] = base + AW'(off) + AW'(p);
  end

  // First byte lands in the most significant of the rd_size low bytes.
  always_comb begin
    value = '0;
    for (int p = 0; p < MAX_RD; p++) begin
      if (LEN_W'(p) < n) begin
        value = value | (VW'(lane_byte[p]) << (8 * (int'(rd_size) - 1 - p)));
      end
    end
  end

endmodule

// File: rtl/cfgsel_image.sv
module cfgsel_image
  import cfgsel_pkg::*;
#(
  parameter int          NPORT    = 8,
  parameter int          AW       = 5,
  parameter logic [31:0] SIG_WORD = 32'h4346_4753,
  parameter bit          DMA_EN   = 1'b0
) (
  input  logic [NPORT-1:0][AW-1:0] addr,
  output logic [NPORT-1:0][7:0]    data
);

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign data[p] = img_byte(int'(addr[p]), SIG_WORD, DMA_EN);
  end

endmodule

// File: rtl/cfgsel_port.sv
module cfgsel_port
  import cfgsel_pkg::*;
#(
  parameter logic [31:0] SIG_WORD   = 32'h4346_4753,
  parameter bit          DMA_EN     = 1'b0,
  parameter int          FIRST_FILE = 32,
  parameter int          FILE_SLOTS = 32,
  parameter int          MAX_RD     = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_valid,
  input  logic                acc_write,
  input  logic [1:0]          acc_space,
  input  logic [3:0]          acc_size,
  input  logic [15:0]         acc_wdata,
  output logic                rsp_valid,
  output logic [8*MAX_RD-1:0] rsp_rdata,
  output logic                rsp_err
);

  localparam int DW     = 8 * MAX_RD;
  localparam int IMG_AW = (IMG_BYTES > 1) ? $clog2(IMG_BYTES) : 1;

  // Reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic            sel_we, rd_en, ign_wr, reject;
  logic [SZ_W-1:0] rd_size;

  cfgsel_decode #(.MAX_RD(MAX_RD)) u_decode (
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_space (acc_space),
    .acc_size  (acc_size),
    .sel_we    (sel_we),
    .rd_en     (rd_en),
    .ign_wr    (ign_wr),
    .reject    (reject),
    .rd_size   (rd_size)
  );

  logic unused_key_bit;
  assign unused_key_bit = acc_wdata[14];

  logic             key_ok;
  logic [IMG_AW-1:0] cur_base;
  logic [LEN_W-1:0] cur_len, off, adv;

  cfgsel_state #(
    .FIRST_FILE (FIRST_FILE),
    .FILE_SLOTS (FILE_SLOTS),
    .AW         (IMG_AW)
  ) u_state (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .sel_we   (sel_we),
    .sel_bank (acc_wdata[BANK_POS]),
    .sel_idx  (acc_wdata[IDX_W-1:0]),
    .rd_en    (rd_en),
    .adv      (adv),
    .key_ok   (key_ok),
    .cur_base (cur_base),
    .cur_len  (cur_len),
    .off      (off)
  );

  logic [MAX_RD-1:0][IMG_AW-1:0] lane_addr;
  logic [MAX_RD-1:0][7:0]        lane_byte;
  logic [DW-1:0]                 value;

  cfgsel_lanes #(.MAX_RD(MAX_RD), .AW(IMG_AW)) u_lanes (
    .key_ok    (key_ok),
    .base      (cur_base),
    .len       (cur_len),
    .off       (off),
    .rd_size   (rd_size),
    .lane_byte (lane_byte),
    .lane_addr (lane_addr),
    .value     (value),
    .adv       (adv)
  );

  cfgsel_image #(
    .NPORT    (MAX_RD),
    .AW       (IMG_AW),
    .SIG_WORD (SIG_WORD),
    .DMA_EN   (DMA_EN)
  ) u_image (
    .addr (lane_addr),
    .data (lane_byte)
  );

  // Response stage
  logic          rsp_valid_q, rsp_valid_n;
  logic          rsp_err_q, rsp_err_n;
  logic [DW-1:0] rsp_data_q, rsp_data_n;
  logic          rsp_en;

  always_comb begin
    rsp_en      = acc_valid || rsp_valid_q;
    rsp_valid_n = acc_valid;
    rsp_err_n   = reject;
    rsp_data_n  = rd_en ? value : '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_data_q  <= '0;
    end else if (rsp_en) begin
      rsp_valid_q <= rsp_valid_n;
      rsp_err_q   <= rsp_err_n;
      rsp_data_q  <= rsp_data_n;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_err   = rsp_err_q;
  assign rsp_rdata = rsp_data_q;

  AST_ERR_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_err |-> rsp_rdata == '0);  // R10
  AST_ERR_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_err |-> rsp_valid);  // R10
  AST_CTL_READ_REJECT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_valid && acc_space == 2'd0 && !acc_write) |=> rsp_err);  // R8
  AST_DATA_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_valid && acc_space == 2'd1 && acc_write && acc_size == 4'd1)
      |=> rsp_valid && !rsp_err && rsp_rdata == '0);  // R7
  AST_COMB_WORD_READ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_valid && acc_space == 2'd2 && !acc_write && acc_size == 4'd2) |=> rsp_err);  // R9
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_sync_n)
    acc_valid |-> $onehot({sel_we, rd_en, ign_wr, reject}));  // R9
  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    acc_valid |=> rsp_valid);  // R5

endmodule

// File: tb/cfgsel_port_bench.sv
module cfgsel_port_bench;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid, acc_write;
  logic [1:0]  acc_space;
  logic [3:0]  acc_size;
  logic [15:0] acc_wdata;
  logic        rsp_valid, rsp_err;
  logic [63:0] rsp_rdata;

  always #2.5 clk = ~clk;

  cfgsel_port u_cfgsel_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_space (acc_space),
    .acc_size  (acc_size),
    .acc_wdata (acc_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err)
  );

  int checks = 0;
  int errs   = 0;
  bit done   = 1'b0;

  localparam logic [63:0] SIG = 64'h0000_0000_4346_4753;
  localparam logic [1:0] CT = 2'd0, DT = 2'd1, CB = 2'd2, NO = 2'd3;

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic acc(input logic [1:0] sp, input logic wr, input logic [3:0] sz,
                     input logic [15:0] wd, output logic [63:0] rd,
                     output logic er, output logic vl);
    @(negedge clk);
    acc_valid = 1'b1;
    acc_write = wr;
    acc_space = sp;
    acc_size  = sz;
    acc_wdata = wd;
    @(posedge clk);
    #1;
    rd = rsp_rdata;
    er = rsp_err;
    vl = rsp_valid;
    @(negedge clk);
    acc_valid = 1'b0;
    acc_write = 1'b0;
  endtask

  // {req, space, write, size, wdata, exp_err, exp_rdata}
  localparam int NV = 41;
  localparam logic [91:0] VEC [NV] = '{
    {4'd1,  DT, 1'b0, 4'd4, 16'h0000, 1'b0, SIG},                    // R1 signature
    {4'd6,  DT, 1'b0, 4'd2, 16'h0000, 1'b0, 64'h0},                  // R6 exhausted
    {4'd2,  CT, 1'b1, 4'd2, 16'h0020, 1'b0, 64'h0},                  // R2 select
    {4'd5,  DT, 1'b0, 4'd3, 16'h0000, 1'b0, 64'h0000_0000_0000_0102},// R5
    {4'd5,  DT, 1'b0, 4'd8, 16'h0000, 1'b0, 64'h0304_0506_0708_090A},// R5 exact end
    {4'd6,  DT, 1'b0, 4'd4, 16'h0000, 1'b0, 64'h0},                  // R6 past end
    {4'd2,  CT, 1'b1, 4'd2, 16'h0020, 1'b0, 64'h0},                  // R2 reselect
    {4'd5,  DT, 1'b0, 4'd8, 16'h0000, 1'b0, 64'h0001_0203_0405_0607},// R5
    {4'd5,  DT, 1'b0, 4'd8, 16'h0000, 1'b0, 64'h0809_0A00_0000_0000},// R5 zero pad
    {4'd4,  CT, 1'b1, 4'd2, 16'h8020, 1'b0, 64'h0},                  // R4 bank 1
    {4'd4,  DT, 1'b0, 4'd8, 16'h0000, 1'b0, 64'h8081_8283_8400_0000},// R4
    {4'd3,  CT, 1'b1, 4'd2, 16'h003F, 1'b0, 64'h0},                  // R3 last slot
    {4'd3,  DT, 1'b0, 4'd2, 16'h0000, 1'b0, 64'h0000_0000_0000_7071},// R3
    {4'd3,  CT, 1'b1, 4'd2, 16'h0040, 1'b0, 64'h0},                  // R3 at limit
    {4'd3,  DT, 1'b0, 4'd8, 16'h0000, 1'b0, 64'h0},                  // R3
    {4'd3,  CT, 1'b1, 4'd2, 16'h8040, 1'b0, 64'h0},                  // R3 bank 1 limit
    {4'd3,  DT, 1'b0, 4'd4, 16'h0000, 1'b0, 64'h0},                  // R3
    {4'd3,  CT, 1'b1, 4'd2, 16'h4000, 1'b0, 64'h0},                  // R3 bit 14
    {4'd3,  DT, 1'b0, 4'd4, 16'h0000, 1'b0, SIG},                    // R3
    {4'd11, CT, 1'b1, 4'd2, 16'h0001, 1'b0, 64'h0},                  // R11 version
    {4'd11, DT, 1'b0, 4'd4, 16'h0000, 1'b0, 64'h0000_0000_0100_0000},// R11
    {4'd6,  CT, 1'b1, 4'd2, 16'h0002, 1'b0, 64'h0},                  // R6 empty item
    {4'd6,  DT, 1'b0, 4'd1, 16'h0000, 1'b0, 64'h0},                  // R6
    {4'd9,  CB, 1'b1, 4'd2, 16'h0020, 1'b0, 64'h0},                  // R9 combined select
    {4'd9,  CB, 1'b0, 4'd1, 16'h0000, 1'b0, 64'h00},                 // R9
    {4'd9,  CB, 1'b0, 4'd1, 16'h0000, 1'b0, 64'h01},                 // R9
    {4'd7,  DT, 1'b1, 4'd1, 16'h00FF, 1'b0, 64'h0},                  // R7 data write
    {4'd7,  CB, 1'b1, 4'd1, 16'h00FF, 1'b0, 64'h0},                  // R7 combined byte write
    {4'd7,  CB, 1'b0, 4'd1, 16'h0000, 1'b0, 64'h02},                 // R7 offset kept
    {4'd8,  CT, 1'b0, 4'd2, 16'h0000, 1'b1, 64'h0},                  // R8 control read
    {4'd8,  CT, 1'b1, 4'd1, 16'h0001, 1'b1, 64'h0},                  // R8 byte write
    {4'd8,  CT, 1'b1, 4'd4, 16'h0001, 1'b1, 64'h0},                  // R8 word write
    {4'd10, CB, 1'b0, 4'd1, 16'h0000, 1'b0, 64'h03},                 // R10 state kept
    {4'd9,  CB, 1'b0, 4'd2, 16'h0000, 1'b1, 64'h0},                  // R9 2-byte read
    {4'd10, DT, 1'b0, 4'd0, 16'h0000, 1'b1, 64'h0},                  // R10 size 0
    {4'd10, DT, 1'b0, 4'd9, 16'h0000, 1'b1, 64'h0},                  // R10 size 9
    {4'd10, NO, 1'b0, 4'd1, 16'h0000, 1'b1, 64'h0},                  // R10 unmapped
    {4'd9,  CB, 1'b1, 4'd4, 16'h0040, 1'b1, 64'h0},                  // R9 wide write
    {4'd10, DT, 1'b0, 4'd1, 16'h0000, 1'b0, 64'h04},                 // R10 state kept
    {4'd12, CT, 1'b1, 4'd2, 16'h8000, 1'b0, 64'h0},                  // R12 bank 1 idx 0
    {4'd12, DT, 1'b0, 4'd4, 16'h0000, 1'b0, 64'h0}                   // R12 no item
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL R1 watchdog actual=timeout expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] rd;
    logic        er, vl;
    rst_n     = 1'b0;
    acc_valid = 1'b0;
    acc_write = 1'b0;
    acc_space = 2'd0;
    acc_size  = 4'd0;
    acc_wdata = 16'h0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset rsp_valid", 64'(rsp_valid), 64'h0);
    check("R1 reset rsp_err", 64'(rsp_err), 64'h0);
    check("R1 reset rsp_rdata", rsp_rdata, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [91:0] v;
      v = VEC[i];
      acc(v[87:86], v[85], v[84:81], v[80:65], rd, er, vl);
      check($sformatf("R%0d vec %0d rdata", v[91:88], i), rd, v[63:0]);
      check($sformatf("R%0d vec %0d err", v[91:88], i), 64'(er), 64'(v[64]));
      check($sformatf("R%0d vec %0d valid", v[91:88], i), 64'(vl), 64'h1);
    end

    // R10: error lasts one cycle only
    acc(CT, 1'b0, 4'd2, 16'h0, rd, er, vl);
    check("R10 reject err", 64'(er), 64'h1);
    @(posedge clk);
    #1;
    check("R10 err one cycle", 64'(rsp_err), 64'h0);
    check("R10 valid drops", 64'(rsp_valid), 64'h0);

    // R5 boundary on the 2-byte item
    acc(CT, 1'b1, 4'd2, 16'h003F, rd, er, vl);
    acc(DT, 1'b0, 4'd1, 16'h0, rd, er, vl);
    check("R5 first byte", rd, 64'h70);
    acc(DT, 1'b0, 4'd8, 16'h0, rd, er, vl);
    check("R5 pad after last byte", rd, 64'h7100_0000_0000_0000);
    acc(DT, 1'b0, 4'd1, 16'h0, rd, er, vl);
    check("R6 after end", rd, 64'h0);

    // R2: reselecting the same key restarts the item
    acc(CB, 1'b1, 4'd2, 16'h8020, rd, er, vl);
    acc(CB, 1'b0, 4'd1, 16'h0, rd, er, vl);
    acc(CB, 1'b0, 4'd1, 16'h0, rd, er, vl);
    check("R2 second byte", rd, 64'h81);
    acc(CB, 1'b1, 4'd2, 16'h8020, rd, er, vl);
    acc(CB, 1'b0, 4'd1, 16'h0, rd, er, vl);
    check("R2 restart", rd, 64'h80);

    // R1: reset in the middle of an item returns to key 0
    acc(CT, 1'b1, 4'd2, 16'h0020, rd, er, vl);
    acc(DT, 1'b0, 4'd2, 16'h0, rd, er, vl);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async reset valid", 64'(rsp_valid), 64'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    acc(DT, 1'b0, 4'd8, 16'h0, rd, er, vl);
    check("R1 signature after reset", rd, 64'h4346_4753_0000_0000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule